// File: doc/BRIEF.md
# Channel Test Interface Controller

This block is a maintenance test peripheral for an I/O channel. It holds a control register and one data register. The data register can work as a plain data buffer, as a counter of transferred words, or as the reference for comparing write data. The channel starts an order (control, write or read), and the words of that order then move over two valid/ready streams: one inbound for control and write words, one outbound for read data. A direct-write port can preload the data register at any time, for example to set a device number before an I/O program starts.

The control register sets how the two words of a control order are routed. It can switch service-request pacing from the normal divided rate to continuous requests. It can replace the wired device number with the data register value. It can also arm two ending conditions: counter rollover and write-data mismatch. When an armed condition hits, the block ends the transfer with either a device-end pulse or a clear-interface pulse, as the control register selects. After that it refuses further words until the next order starts.

Stream rules: `in_ready` and `out_valid` do not depend on `in_valid` or `out_ready`. A word moves on a clock edge where both valid and ready are high. Once `out_valid` is high it stays high, with `out_data` stable, until the word is taken or a new order starts. The channel may hold `in_valid` high or low for as long as it likes.

Top module: `chti_top`

## Requirements
- R1: After reset (`rst_n` low) the data register is zero and the control register is zero. So `dev_num` shows the wired number, read orders return 0, the data register acts as a buffer, and `dev_end`, `clr_req`, `in_ready` and `out_valid` are low.
- R2: A cycle with `dw_valid` high loads `dw_data` into the data register. This load takes priority over any stream update in the same cycle.
- R3: In buffer mode (control bits 15:13 = 000) a write-order word is stored in the data register, and each read-order word returns the register value.
- R4: In count mode (bits 15:13 = 001) each data word moved by a write or read order increments the register by one, and write data is not stored. A read returns the value before the increment. Codes 010 to 111 behave as buffer mode.
- R5: A control order takes exactly two inbound words. Bits 7:6 route them. With 00, the second word is written into the control register and the first is dropped. With 01, the first word goes to the data register. With 10, the second word goes to the data register. With 11, both go to the data register in turn, so the second word remains. Codes 01, 10 and 11 leave the control register unchanged.
- R6: `dev_num` equals the data register when bit 9 is set, and the `WIRED_DEV` parameter when bit 9 is clear.
- R7: With bit 10 set and count mode active, a data word moved while the register holds all ones wraps it to zero and ends the transfer.
- R8: With bit 11 set, each write-order word is compared with the data register, and the register is not loaded. A mismatch ends the transfer; a match does not.
- R9: The ending is a one-cycle pulse in the cycle after the offending word: `clr_req` if bit 12 is set, otherwise `dev_end`. The two pulses never occur together.
- R10: After an ending, `in_ready` and `out_valid` stay low until `ord_start` begins a new order.
- R11: With bit 8 clear, a request (`srq`) appears only after a full divider period of `CLK_HZ/SR_HZ` cycles has passed since the last moved word, so consecutive words are at least that many plus one cycles apart. With bit 8 set, the request stays high and words can move on every cycle.
- R12: `ord_kind` codes are 0 none, 1 control, 2 write and 3 read. `in_ready` is only high for control or write orders, and `out_valid` only for read orders. Both are low in a cycle where `ord_start` is high. A raised `out_valid` holds, with stable data, until the word is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous I/O reset |
| dw_valid | input | 1 | Direct write strobe for the data register |
| dw_data | input | DW | Direct write value |
| ord_start | input | 1 | Starts a new order |
| ord_kind | input | 2 | Order kind, sampled with `ord_start` |
| in_valid | input | 1 | Inbound word valid |
| in_ready | output | 1 | Inbound word accepted when high with `in_valid` |
| in_data | input | DW | Inbound control or write word |
| out_valid | output | 1 | Read word available |
| out_ready | input | 1 | Channel takes the read word |
| out_data | output | DW | Read word (data register value) |
| srq | output | 1 | Service request |
| dev_num | output | DW | Device number presented at program start |
| dev_end | output | 1 | Device-end pulse |
| clr_req | output | 1 | Clear-interface pulse |

## Verification
The bench targets the word that takes the counter from all ones to zero, and checks that it wraps and fires exactly one pulse of the selected kind. An off-by-one would end a word early or never end at all. It sends a matching word and then a mismatching word in compare mode. A design that loads compare data would then show the wrong device number, and one that ignores the match would end too soon. Each routing code is run from a fresh reset, because a design that writes the control register in a non-normal mode would change the routing for later orders. Word spacing is measured in both pacing modes, and a held read word is watched for drops or data changes.

// File: rtl/chti_pkg.sv
package chti_pkg;
  typedef enum logic [1:0] {
    ORD_NONE  = 2'd0,
    ORD_CTRL  = 2'd1,
    ORD_WRITE = 2'd2,
    ORD_READ  = 2'd3
  } ord_e;

  typedef enum logic [1:0] {
    RT_NORMAL = 2'd0,
    RT_FIRST  = 2'd1,
    RT_SECOND = 2'd2,
    RT_BOTH   = 2'd3
  } route_e;

  // control register bit positions
  localparam int RT_LO    = 6;
  localparam int RT_HI    = 7;
  localparam int FAST_B   = 8;
  localparam int DEVSRC_B = 9;
  localparam int ROLL_B   = 10;
  localparam int CMP_B    = 11;
  localparam int ENDSEL_B = 12;
  localparam int OP_LO    = 13;
  localparam int OP_HI    = 15;

  localparam logic [2:0] OP_COUNT = 3'b001;
endpackage

// File: rtl/chti_pace.sv
module chti_pace #(
  parameter int DIV = 625
) (
  input  logic clk,
  input  logic rst_n,
  input  logic need,
  input  logic fast,
  input  logic beat,
  output logic req
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;
  logic          permit_q;
  logic          tick;

  assign tick = (cnt_q == CW'(DIV - 1));

  // divider restarts on every moved word
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (beat || tick)  cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              permit_q <= 1'b0;
    else if (!need || beat)  permit_q <= 1'b0;
    else if (tick)           permit_q <= 1'b1;
  end

  assign req = need && (fast || permit_q);
endmodule

// File: rtl/chti_cbuf.sv
module chti_cbuf #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dw_valid,
  input  logic [DW-1:0] dw_data,
  input  logic          ld_en,
  input  logic [DW-1:0] ld_data,
  input  logic          inc_en,
  output logic [DW-1:0] cb_q,
  output logic          at_max
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cb_q <= '0;
    else if (dw_valid) cb_q <= dw_data;
    else if (ld_en)    cb_q <= ld_data;
    else if (inc_en)   cb_q <= cb_q + 1'b1;
  end

  assign at_max = &cb_q;
endmodule

// File: rtl/chti_seq.sv
module chti_seq
  import chti_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ord_start,
  input  logic [1:0] ord_kind,
  input  logic       ctrl_beat,
  input  logic       term,
  input  logic       end_sel,
  output ord_e       kind_q,
  output logic       ctrl_idx,
  output logic       need,
  output logic       dev_end,
  output logic       clr_req
);
  logic halted_q, done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q   <= ORD_NONE;
      ctrl_idx <= 1'b0;
      done_q   <= 1'b0;
      halted_q <= 1'b0;
      dev_end  <= 1'b0;
      clr_req  <= 1'b0;
    end else begin
      dev_end <= 1'b0;
      clr_req <= 1'b0;
      if (ord_start) begin
        kind_q   <= ord_e'(ord_kind);
        ctrl_idx <= 1'b0;
        done_q   <= 1'b0;
        halted_q <= 1'b0;
      end else begin
        if (ctrl_beat) begin
          ctrl_idx <= 1'b1;
          if (ctrl_idx) done_q <= 1'b1;
        end
        if (term) begin
          halted_q <= 1'b1;
          dev_end  <= !end_sel;
          clr_req  <= end_sel;
        end
      end
    end
  end

  assign need = (kind_q != ORD_NONE) && !halted_q && !done_q;
endmodule

// File: rtl/chti_top.sv
module chti_top
  import chti_pkg::*;
#(
  parameter int              DW        = 16,
  parameter int              CLK_HZ    = 125_000_000,
  parameter int              SR_HZ     = 200_000,
  parameter logic [DW-1:0]   WIRED_DEV = 16'h0007,
  localparam int             DIV       = CLK_HZ / SR_HZ
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dw_valid,
  input  logic [DW-1:0] dw_data,
  input  logic          ord_start,
  input  logic [1:0]    ord_kind,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          srq,
  output logic [DW-1:0] dev_num,
  output logic          dev_end,
  output logic          clr_req
);
  // only the bits that carry meaning are stored
  logic [DW-1:RT_LO] ctl_q;
  logic [DW-1:0]     cb_q;
  ord_e              kind_q;
  logic              ctrl_idx, need, req, at_max;
  logic              beat_in, beat_out, beat;
  logic              wr_beat, ctrl_beat, data_beat;
  logic              op_cnt, cmp_on, inc_en, wr_load;
  logic              to_cb, to_ctl, ld_en, roll_hit, miss_hit, term;
  route_e            rt;

  assign rt     = route_e'(ctl_q[RT_HI:RT_LO]);
  assign op_cnt = (ctl_q[OP_HI:OP_LO] == OP_COUNT);
  assign cmp_on = ctl_q[CMP_B];

  assign in_ready  = req && !ord_start &&
                     ((kind_q == ORD_CTRL) || (kind_q == ORD_WRITE));
  assign out_valid = req && !ord_start && (kind_q == ORD_READ);
  assign srq       = req;

  assign beat_in   = in_valid && in_ready;
  assign beat_out  = out_valid && out_ready;
  assign beat      = beat_in || beat_out;
  assign wr_beat   = beat_in && (kind_q == ORD_WRITE);
  assign ctrl_beat = beat_in && (kind_q == ORD_CTRL);
  assign data_beat = wr_beat || beat_out;

  assign inc_en  = data_beat && op_cnt;
  assign wr_load = wr_beat && !op_cnt && !cmp_on;

  always_comb begin
    to_cb  = 1'b0;
    to_ctl = 1'b0;
    if (ctrl_beat) begin
      unique case (rt)
        RT_NORMAL: to_ctl = ctrl_idx;
        RT_FIRST:  to_cb  = !ctrl_idx;
        RT_SECOND: to_cb  = ctrl_idx;
        RT_BOTH:   to_cb  = 1'b1;
      endcase
    end
  end

  assign ld_en    = wr_load || to_cb;
  assign roll_hit = inc_en && at_max && ctl_q[ROLL_B];
  assign miss_hit = wr_beat && cmp_on && (in_data != cb_q);
  assign term     = roll_hit || miss_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (to_ctl) ctl_q <= in_data[DW-1:RT_LO];
  end

  chti_cbuf #(.DW(DW)) u_cbuf (
    .clk(clk), .rst_n(rst_n),
    .dw_valid(dw_valid), .dw_data(dw_data),
    .ld_en(ld_en), .ld_data(in_data),
    .inc_en(inc_en), .cb_q(cb_q), .at_max(at_max)
  );

  chti_seq u_seq (
    .clk(clk), .rst_n(rst_n),
    .ord_start(ord_start), .ord_kind(ord_kind),
    .ctrl_beat(ctrl_beat), .term(term), .end_sel(ctl_q[ENDSEL_B]),
    .kind_q(kind_q), .ctrl_idx(ctrl_idx), .need(need),
    .dev_end(dev_end), .clr_req(clr_req)
  );

  chti_pace #(.DIV(DIV)) u_pace (
    .clk(clk), .rst_n(rst_n),
    .need(need), .fast(ctl_q[FAST_B]), .beat(beat), .req(req)
  );

  assign out_data = cb_q;
  assign dev_num  = ctl_q[DEVSRC_B] ? cb_q : WIRED_DEV;
endmodule

// File: rtl/chti_chk.sv
module chti_chk #(
  parameter int DIV = 625,
  parameter int DW  = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data,
  input logic          ord_start,
  input logic          dw_valid,
  input logic          dev_end,
  input logic          clr_req,
  input logic          fast,
  input logic          cmp_on,
  input logic          op_cnt,
  input logic [1:0]    kind,
  input logic [DW-1:0] cb
);
  localparam int GW = $clog2(DIV + 2) + 1;

  logic          beat;
  logic [GW-1:0] gap_q;
  logic          seen_q;

  assign beat = (in_valid && in_ready) || (out_valid && out_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (beat) begin
      gap_q  <= GW'(1);
      seen_q <= 1'b1;
    end else if (gap_q != '1) begin
      gap_q  <= gap_q + 1'b1;
    end
  end

  // R9
  end_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dev_end && clr_req));
  // R9
  end_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_end || clr_req) |=> !(dev_end || clr_req));
  // R10
  halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_end || clr_req) |-> (!in_ready && !out_valid));
  // R11
  pace_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !fast && seen_q) |-> (gap_q > GW'(DIV)));
  // R12
  dir_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));
  // R12
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(out_valid && !out_ready) && !ord_start) |-> out_valid);
  // R12
  rd_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(out_valid && !out_ready && !dw_valid) && !ord_start) |-> $stable(out_data));
  // R8
  cmp_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && kind == 2'd2 && cmp_on && !op_cnt && !dw_valid) |=> $stable(cb));
endmodule

bind chti_top chti_chk #(.DIV(DIV), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .ord_start(ord_start), .dw_valid(dw_valid),
  .dev_end(dev_end), .clr_req(clr_req),
  .fast(ctl_q[chti_pkg::FAST_B]), .cmp_on(ctl_q[chti_pkg::CMP_B]),
  .op_cnt(ctl_q[chti_pkg::OP_HI:chti_pkg::OP_LO] == chti_pkg::OP_COUNT),
  .kind(kind_q), .cb(cb_q)
);

// File: tb/sim_chti_top.sv
module sim_chti_top;
  localparam int          DW    = 16;
  localparam int          DIV   = 5;
  localparam logic [15:0] WIRED = 16'h00A5;

  localparam logic [3:0] OP_DW = 0, OP_ST = 1, OP_WR = 2, OP_RD = 3,
                         OP_DEV = 4, OP_CTL = 5, OP_RST = 6;
  localparam int N = 49;
  // {op, requirement, a, b}
  localparam logic [39:0] TBL [N] = '{
    {OP_DW, 4'd2, 16'h1234, 16'h0}, {OP_DEV, 4'd6, WIRED, 16'h0},       // R2 R6
    {OP_ST, 4'd2, 16'h0003, 16'h0}, {OP_RD, 4'd2, 16'h1234, 16'h0},     // R2
    {OP_ST, 4'd3, 16'h0002, 16'h0}, {OP_WR, 4'd3, 16'hBEEF, 16'h0},     // R3
    {OP_ST, 4'd3, 16'h0003, 16'h0}, {OP_RD, 4'd3, 16'hBEEF, 16'h0},
    {OP_RD, 4'd3, 16'hBEEF, 16'h0},
    {OP_ST, 4'd5, 16'h0001, 16'h0}, {OP_CTL, 4'd5, 16'h0000, 16'h0200}, // R5
    {OP_DEV, 4'd6, 16'hBEEF, 16'h0},
    {OP_DW, 4'd2, 16'h0042, 16'h0}, {OP_DEV, 4'd6, 16'h0042, 16'h0},
    {OP_ST, 4'd5, 16'h0001, 16'h0}, {OP_CTL, 4'd5, 16'h1111, 16'h2222},
    {OP_ST, 4'd4, 16'h0002, 16'h0}, {OP_WR, 4'd4, 16'h9999, 16'h0},     // R4
    {OP_DEV, 4'd4, 16'h0043, 16'h0},
    {OP_ST, 4'd4, 16'h0003, 16'h0}, {OP_RD, 4'd4, 16'h0043, 16'h0},
    {OP_RD, 4'd4, 16'h0044, 16'h0}, {OP_DEV, 4'd4, 16'h0045, 16'h0},
    {OP_ST, 4'd5, 16'h0001, 16'h0}, {OP_CTL, 4'd5, 16'h1111, 16'h0240},
    {OP_ST, 4'd5, 16'h0001, 16'h0}, {OP_CTL, 4'd5, 16'hABCD, 16'h5555},
    {OP_DEV, 4'd5, 16'hABCD, 16'h0},
    {OP_RST, 4'd1, 16'h0, 16'h0},   {OP_DEV, 4'd1, WIRED, 16'h0},       // R1
    {OP_ST, 4'd1, 16'h0003, 16'h0}, {OP_RD, 4'd1, 16'h0000, 16'h0},
    {OP_ST, 4'd5, 16'h0001, 16'h0}, {OP_CTL, 4'd5, 16'h0000, 16'h0280},
    {OP_ST, 4'd5, 16'h0001, 16'h0}, {OP_CTL, 4'd5, 16'h1357, 16'h2468},
    {OP_DEV, 4'd5, 16'h2468, 16'h0},
    {OP_RST, 4'd1, 16'h0, 16'h0},
    {OP_ST, 4'd5, 16'h0001, 16'h0}, {OP_CTL, 4'd5, 16'h0000, 16'h02C0},
    {OP_ST, 4'd5, 16'h0001, 16'h0}, {OP_CTL, 4'd5, 16'h0F0F, 16'h7777},
    {OP_DEV, 4'd5, 16'h7777, 16'h0},
    {OP_RST, 4'd1, 16'h0, 16'h0},
    {OP_ST, 4'd4, 16'h0001, 16'h0}, {OP_CTL, 4'd4, 16'h0000, 16'h8200},
    {OP_ST, 4'd4, 16'h0002, 16'h0}, {OP_WR, 4'd4, 16'h3C3C, 16'h0},
    {OP_DEV, 4'd4, 16'h3C3C, 16'h0}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          dw_valid, ord_start, in_valid, out_ready;
  logic [DW-1:0] dw_data, in_data;
  logic [1:0]    ord_kind;
  logic          in_ready, out_valid, srq, dev_end, clr_req;
  logic [DW-1:0] out_data, dev_num;

  int  checks = 0;
  int  fails  = 0;
  int  cyc    = 0;
  bit  ended  = 0;
  time beat_t;

  always #4 clk = ~clk;

  chti_top #(.DW(DW), .CLK_HZ(125_000_000), .SR_HZ(25_000_000), .WIRED_DEV(WIRED)) u0 (
    .clk(clk), .rst_n(rst_n), .dw_valid(dw_valid), .dw_data(dw_data),
    .ord_start(ord_start), .ord_kind(ord_kind),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .srq(srq), .dev_num(dev_num), .dev_end(dev_end), .clr_req(clr_req)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !ended) begin
      chk(0, "R12 watchdog expired", 32'(cyc), 0);
      finish_up();
    end
  end

  task automatic do_reset();
    rst_n = 0; dw_valid = 0; ord_start = 0; in_valid = 0; out_ready = 0;
    dw_data = '0; in_data = '0; ord_kind = 2'd0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic start(input logic [1:0] k);
    ord_start = 1; ord_kind = k;
    @(negedge clk);
    ord_start = 0;
  endtask

  task automatic dwrite(input logic [15:0] v);
    dw_valid = 1; dw_data = v;
    @(negedge clk);
    dw_valid = 0;
  endtask

  task automatic put(input logic [15:0] w);
    int n = 0;
    in_valid = 1; in_data = w; #1;
    while (!in_ready && n < 200) begin @(negedge clk); #1; n++; end
    if (!in_ready) begin
      chk(0, "R12 inbound never ready", 0, 1);
      in_valid = 0;
    end else begin
      @(posedge clk); beat_t = $time;
      @(negedge clk);
      in_valid = 0;
    end
  endtask

  task automatic get(output logic [15:0] v);
    int n = 0;
    out_ready = 1; #1;
    while (!out_valid && n < 200) begin @(negedge clk); #1; n++; end
    v = out_data;
    if (!out_valid) chk(0, "R12 read never valid", 0, 1);
    else begin @(posedge clk); @(negedge clk); end
    out_ready = 0;
  endtask

  initial begin
    logic [15:0] v, v0;
    time t1, t2, t3;
    do_reset();
    #1;
    chk(dev_end == 0 && clr_req == 0, "R1 no pulse after reset", {dev_end, clr_req}, 0);
    chk(in_ready == 0 && out_valid == 0, "R1 streams idle after reset", {in_ready, out_valid}, 0);
    chk(dev_num == WIRED, "R1 wired device number", dev_num, WIRED);

    for (int i = 0; i < N; i++) begin
      logic [3:0]  op;
      logic [3:0]  rq;
      logic [15:0] a, b;
      {op, rq, a, b} = TBL[i];
      case (op)
        OP_DW:  dwrite(a);
        OP_ST:  start(a[1:0]);
        OP_WR:  put(a);
        OP_CTL: begin put(a); put(b); end
        OP_RST: do_reset();
        OP_RD:  begin get(v); chk(v == a, $sformatf("R%0d read word %0d", rq, i), v, a); end
        OP_DEV: begin #1; chk(dev_num == a, $sformatf("R%0d device number %0d", rq, i), dev_num, a); end
        default: ;
      endcase
    end

    // rollover ending, device-end response
    do_reset();
    start(2'd1); put(16'h0000); put(16'h2400);
    dwrite(16'hFFFE);
    start(2'd2);
    put(16'h0001);
    chk(dev_end == 0, "R7 no end at FFFF", dev_end, 0);
    put(16'h0002);
    chk(dev_end == 1, "R7 rollover ends", dev_end, 1);
    chk(clr_req == 0, "R9 device end selected", clr_req, 0);
    chk(in_ready == 0, "R10 halted after end", in_ready, 0);
    @(negedge clk); #1;
    chk(dev_end == 0, "R9 single cycle pulse", dev_end, 0);
    for (int k = 0; k < 2 * DIV; k++) begin
      @(negedge clk); #1;
      if (in_ready) chk(0, "R10 ready while halted", 1, 0);
    end
    chk(in_ready == 0, "R10 still halted", in_ready, 0);
    start(2'd3); get(v);
    chk(v == 16'h0000, "R7 wrapped to zero", v, 0);

    // compare ending, clear-interface response
    do_reset();
    start(2'd1); put(16'h0000); put(16'h1A00);
    dwrite(16'h00AA);
    start(2'd2);
    put(16'h00AA);
    chk(dev_end == 0 && clr_req == 0, "R8 match does not end", {dev_end, clr_req}, 0);
    put(16'h00AB);
    chk(clr_req == 1, "R9 clear-interface selected", clr_req, 1);
    chk(dev_end == 0, "R9 no device end", dev_end, 0);
    chk(dev_num == 16'h00AA, "R8 compare data not stored", dev_num, 16'h00AA);
    chk(in_ready == 0, "R10 halted after mismatch", in_ready, 0);
    start(2'd2);
    repeat (DIV + 3) @(negedge clk);
    #1;
    chk(in_ready == 1, "R10 new order resumes", in_ready, 1);

    // fast service request
    do_reset();
    start(2'd1); put(16'h0000); put(16'h0100);
    start(2'd2);
    put(16'h0001); t1 = beat_t;
    put(16'h0002); t2 = beat_t;
    put(16'h0003); t3 = beat_t;
    chk((t2 - t1) == 8 && (t3 - t2) == 8, "R11 back to back in fast mode",
        32'(t3 - t1), 16);

    // paced service request
    do_reset();
    start(2'd2);
    put(16'h0001); t1 = beat_t;
    put(16'h0002); t2 = beat_t;
    chk((t2 - t1) == (DIV + 1) * 8, "R11 paced spacing", 32'(t2 - t1), (DIV + 1) * 8);

    // read word hold and ord_start gating
    do_reset();
    dwrite(16'h5A5A);
    start(2'd3);
    for (int k = 0; k < 20 && !out_valid; k++) begin @(negedge clk); #1; end
    v0 = out_data;
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid == 1 && out_data == v0, "R12 read word held", {out_valid, out_data}, {1'b1, v0});
    ord_start = 1; ord_kind = 2'd3; #1;
    chk(out_valid == 0, "R12 gated during start", out_valid, 0);
    @(negedge clk); ord_start = 0;
    get(v);
    chk(v == 16'h5A5A, "R12 word after restart", v, 16'h5A5A);

    finish_up();
  end
endmodule